// File: doc/BRIEF.md
# Flash Sector Address Translator

This block turns the block and page address registers of a page-organised flash array into the 512-byte sector number that a downstream data mover needs. Software writes eight 16-bit start-address registers and one buffer-control register through a simple register port. It then issues a command strobe with an operation code. One cycle later the block presents a registered result: the first sector, how many sectors to move, and which on-chip buffer (the boot buffer or one of two data buffers) and which sector slot inside it take part.

The array uses 2 KiB pages (four sectors per page) and 64 pages per erase block, so one erase block spans 256 sectors. Parts built from two stacked dies need one extra block-address bit. That bit comes from a density mask derived from the device identifier parameter. The mask is ORed into the block field whenever bit 15 of the block register is set.

Top module: `flash_sector_xlat`

## Requirements
- R1: After reset every start-address register and the buffer-control register read 0, `xfer_valid` is 0, and a transfer command issued before any write yields sector 0 with a count of 1 and the boot buffer at slot 0.
- R2: Register indices 0 to 7 are eight read/write 16-bit start-address registers. A write stores all 16 bits, and a read at the same index returns them.
- R3: A write to index 8 stores bits [11:8] as the buffer address and bits [1:0] as the sector count, where field value 0 means 4 sectors. Reading index 8 returns the buffer address in bits [11:8], bit 1 equal to bit 1 of (count - 1), and 0 elsewhere.
- R4: Operation code 0 (source transfer) takes its block from index 0 and its page from index 7. The result is blockfield*256 + (page & 0xFF), and the count comes from the buffer-control register.
- R5: Operation code 1 (destination transfer) uses the same formula, with the block taken from index 2 and the page from index 3.
- R6: The blockfield is bits [11:0] of the block register, bitwise ORed with the density mask when bit 15 is set. Bits [14:12] are ignored, and the OR does not carry into other bits.
- R7: The density mask is 1 << (6 + ID[6:4]) when bit 3 of the DEV_ID parameter is set, and 0 otherwise. The default ID 0x0048 gives a mask of 1024.
- R8: Operation code 2 (block erase) returns blockfield*256 from the index-0 block with a count of 256, whatever the page registers hold.
- R9: For every accepted command the buffer outputs are taken from the buffer address held at the command: bit 3 gives data buffer versus boot buffer, bit 2 gives the data-buffer bank, and bits [1:0] give the sector slot.
- R10: `xfer_valid` is high for exactly the one cycle after each accepted command. Between commands the result outputs hold their last values. A command uses the register contents from before any write issued in the same cycle.
- R11: Operation code 3 is ignored: no `xfer_valid` follows and the result outputs keep their values.
- R12: Register indices 9 to 15 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register index for read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational read data at `reg_sel` |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Operation: 0 source, 1 destination, 2 erase, 3 reserved |
| xfer_valid | output | 1 | One-cycle pulse marking a new result |
| xfer_sector | output | SECTOR_W (20) | First sector number |
| xfer_count | output | 9 | Number of sectors (1 to 4, or 256) |
| buf_is_data | output | 1 | 1 selects a data buffer, 0 the boot buffer |
| buf_bank | output | 1 | Data-buffer bank |
| buf_offset | output | 2 | Sector slot inside the buffer |

## Verification
Transfers are tried with page values whose low two bits and middle six bits are both non-zero, and with high page bits set. This separates the slot and page fields and shows that bits above 7 are dropped. Block values 0x7FFF, 0x8000, 0x8400 and 0xF123 separate the 12-bit truncation, the density-bit OR, and an OR that must not carry. All four count-field codes and all sixteen buffer addresses are written, so the zero-means-four rule and each buffer-select bit are seen on their own. Back-to-back commands, a command issued in the same cycle as a register write, and the reserved operation code expose any off-by-one-cycle or hold error in the registered result.

// File: rtl/fx_pkg.sv
package fx_pkg;

    localparam int FX_REG_W          = 16;
    localparam int FX_BLK_LOW_W      = 12;
    localparam int FX_SEC_IN_BLK_LG  = 8;   // 64 pages x 4 sectors
    localparam int FX_SEC_IN_PAGE_LG = 2;   // 2 KiB page
    localparam int FX_BUF_W          = 4;
    localparam int FX_CNT_W          = 3;
    localparam int FX_XCNT_W         = FX_SEC_IN_BLK_LG + 1;

    // Register indices whose roles the data mover depends on
    localparam int FX_IDX_SRC_BLK = 0;
    localparam int FX_IDX_DST_BLK = 2;
    localparam int FX_IDX_DST_PG  = 3;
    localparam int FX_IDX_SRC_PG  = 7;

    typedef enum logic [1:0] {
        OP_SRC   = 2'd0,
        OP_DST   = 2'd1,
        OP_ERASE = 2'd2,
        OP_RSVD  = 2'd3
    } fx_op_e;

    typedef struct packed {
        logic       is_data;
        logic       bank;
        logic [1:0] offset;
    } fx_bufsel_t;

    function automatic int fx_mask_pos(logic [15:0] id);
        return id[3] ? (6 + int'(id[6:4])) : -1;
    endfunction

    function automatic logic [31:0] fx_density_mask(logic [15:0] id);
        int pos;
        pos = fx_mask_pos(id);
        return (pos < 0) ? 32'd0 : (32'd1 << pos);
    endfunction

    function automatic int fx_blockfield_width(logic [15:0] id);
        int pos;
        pos = fx_mask_pos(id);
        return ((pos + 1) > FX_BLK_LOW_W) ? (pos + 1) : FX_BLK_LOW_W;
    endfunction

    function automatic logic [31:0] fx_blockfield(logic [15:0] blk, logic [31:0] mask);
        return {20'd0, blk[FX_BLK_LOW_W-1:0]} | (blk[15] ? mask : 32'd0);
    endfunction

    function automatic fx_bufsel_t fx_split_buf(logic [FX_BUF_W-1:0] ba);
        fx_bufsel_t r;
        r.is_data = ba[3];
        r.bank    = ba[2];
        r.offset  = ba[1:0];
        return r;
    endfunction

    function automatic logic [FX_CNT_W-1:0] fx_decode_count(logic [1:0] f);
        return (f == 2'd0) ? 3'd4 : {1'b0, f};
    endfunction

endpackage

// File: rtl/fx_regfile.sv
module fx_regfile
    import fx_pkg::*;
#(
    parameter int NUM_START = 8,
    parameter int SEL_W     = 4
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [SEL_W-1:0]                   sel,
    input  logic [FX_REG_W-1:0]                wdata,
    output logic [FX_REG_W-1:0]                rdata,
    output logic [NUM_START-1:0][FX_REG_W-1:0] start_q,
    output logic [FX_BUF_W-1:0]                buf_q,
    output logic [FX_CNT_W-1:0]                cnt_q
);

    localparam int IDX_W  = $clog2(NUM_START);
    localparam int SB_IDX = NUM_START;

    logic                sb_hit;
    logic [FX_CNT_W-1:0] cnt_m1;

    assign sb_hit = wr_en && (sel == SEL_W'(SB_IDX));

    for (genvar g = 0; g < NUM_START; g++) begin : g_start
        always_ff @(posedge clk) begin
            if (rst) begin
                start_q[g] <= '0;
            end else if (wr_en && (sel == SEL_W'(g))) begin
                start_q[g] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
            cnt_q <= 3'd1;
        end else if (sb_hit) begin
            buf_q <= wdata[8 +: FX_BUF_W];
            cnt_q <= fx_decode_count(wdata[1:0]);
        end
    end

    assign cnt_m1 = cnt_q - 3'd1;

    always_comb begin
        rdata = '0;
        if (int'(sel) < NUM_START) begin
            rdata = start_q[sel[IDX_W-1:0]];
        end else if (sel == SEL_W'(SB_IDX)) begin
            rdata[8 +: FX_BUF_W] = buf_q;
            rdata[1]             = cnt_m1[1];
        end
    end

    // R3: stored count is always a legal sector count
    a_r3_count_legal: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != 3'd0) && (cnt_q <= 3'd4));

    // R3: count only changes through a buffer-control write
    a_r3_count_stable: assert property (@(posedge clk) disable iff (rst)
        !sb_hit |=> $stable(cnt_q) && $stable(buf_q));

    // R12: writes to unmapped indices touch nothing
    a_r12_unmapped_no_effect: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (int'(sel) > SB_IDX)) |=> $stable(start_q) && $stable(buf_q));

endmodule

// File: rtl/fx_sector_calc.sv
module fx_sector_calc
    import fx_pkg::*;
#(
    parameter logic [15:0] DEV_ID    = 16'h0048,
    parameter int          NUM_START = 8,
    parameter int          BF_W      = 12,
    parameter int          SECTOR_W  = 20
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               cmd_valid,
    input  fx_op_e                             cmd_op,
    input  logic [NUM_START-1:0][FX_REG_W-1:0] start_q,
    input  logic [FX_BUF_W-1:0]                buf_q,
    input  logic [FX_CNT_W-1:0]                cnt_q,
    output logic                               xfer_valid,
    output logic [SECTOR_W-1:0]                xfer_sector,
    output logic [FX_XCNT_W-1:0]               xfer_count,
    output fx_bufsel_t                         bufsel
);

    localparam logic [31:0] MASK = fx_density_mask(DEV_ID);

    logic [FX_REG_W-1:0]  blk_sel;
    logic [FX_REG_W-1:0]  pg_sel;
    logic [31:0]          bf_full;
    logic [BF_W-1:0]      bf;
    logic [SECTOR_W-1:0]  sec_next;
    logic [FX_XCNT_W-1:0] cnt_next;
    logic                 accept;
    logic                 unused_calc;

    always_comb begin
        if (cmd_op == OP_DST) begin
            blk_sel = start_q[FX_IDX_DST_BLK];
            pg_sel  = start_q[FX_IDX_DST_PG];
        end else begin
            blk_sel = start_q[FX_IDX_SRC_BLK];
            pg_sel  = start_q[FX_IDX_SRC_PG];
        end
    end

    assign bf_full = fx_blockfield(blk_sel, MASK);
    assign bf      = bf_full[BF_W-1:0];

    // Block, page-in-block and sector-in-page fields tile without carries
    always_comb begin
        if (cmd_op == OP_ERASE) begin
            sec_next = {bf, {FX_SEC_IN_BLK_LG{1'b0}}};
            cnt_next = FX_XCNT_W'(1 << FX_SEC_IN_BLK_LG);
        end else begin
            sec_next = {bf,
                        pg_sel[FX_SEC_IN_BLK_LG-1:FX_SEC_IN_PAGE_LG],
                        pg_sel[FX_SEC_IN_PAGE_LG-1:0]};
            cnt_next = FX_XCNT_W'(cnt_q);
        end
    end

    assign accept = cmd_valid && (cmd_op != OP_RSVD);

    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_valid  <= 1'b0;
            xfer_sector <= '0;
            xfer_count  <= '0;
            bufsel      <= '0;
        end else begin
            xfer_valid <= accept;
            if (accept) begin
                xfer_sector <= sec_next;
                xfer_count  <= cnt_next;
                bufsel      <= fx_split_buf(buf_q);
            end
        end
    end

    assign unused_calc = ^{bf_full, pg_sel[FX_REG_W-1:FX_SEC_IN_BLK_LG],
                           blk_sel[14:FX_BLK_LOW_W], start_q};

    // R10: every accepted command yields a result in the next cycle
    a_r10_valid_follows_cmd: assert property (@(posedge clk) disable iff (rst)
        accept |=> xfer_valid);

    // R10: a result pulse always has an accepted command behind it
    a_r10_valid_needs_cmd: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |-> $past(cmd_valid) && ($past(cmd_op) != OP_RSVD));

    // R11: reserved code leaves the result untouched
    a_r11_rsvd_holds: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_RSVD) |=>
            !xfer_valid && $stable(xfer_sector) && $stable(xfer_count));

    // R8: a whole-block result starts on a block boundary
    a_r8_erase_aligned: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && xfer_count == FX_XCNT_W'(256)) |-> (xfer_sector[7:0] == 8'd0));

endmodule

// File: rtl/flash_sector_xlat.sv
module flash_sector_xlat
    import fx_pkg::*;
#(
    parameter  logic [15:0] DEV_ID    = 16'h0048,
    parameter  int          NUM_START = 8,
    localparam int          SEL_W     = $clog2(NUM_START + 1),
    localparam int          BF_W      = fx_blockfield_width(DEV_ID),
    localparam int          SECTOR_W  = BF_W + FX_SEC_IN_BLK_LG
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [SEL_W-1:0]     reg_sel,
    input  logic [FX_REG_W-1:0]  reg_wdata,
    output logic [FX_REG_W-1:0]  reg_rdata,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    output logic                 xfer_valid,
    output logic [SECTOR_W-1:0]  xfer_sector,
    output logic [FX_XCNT_W-1:0] xfer_count,
    output logic                 buf_is_data,
    output logic                 buf_bank,
    output logic [1:0]           buf_offset
);

    logic [NUM_START-1:0][FX_REG_W-1:0] start_q;
    logic [FX_BUF_W-1:0]                buf_q;
    logic [FX_CNT_W-1:0]                cnt_q;
    fx_bufsel_t                         bufsel;

    fx_regfile #(
        .NUM_START (NUM_START),
        .SEL_W     (SEL_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .sel     (reg_sel),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .start_q (start_q),
        .buf_q   (buf_q),
        .cnt_q   (cnt_q)
    );

    fx_sector_calc #(
        .DEV_ID    (DEV_ID),
        .NUM_START (NUM_START),
        .BF_W      (BF_W),
        .SECTOR_W  (SECTOR_W)
    ) u_calc (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_op      (fx_op_e'(cmd_op)),
        .start_q     (start_q),
        .buf_q       (buf_q),
        .cnt_q       (cnt_q),
        .xfer_valid  (xfer_valid),
        .xfer_sector (xfer_sector),
        .xfer_count  (xfer_count),
        .bufsel      (bufsel)
    );

    assign buf_is_data = bufsel.is_data;
    assign buf_bank    = bufsel.bank;
    assign buf_offset  = bufsel.offset;

endmodule

// File: tb/tb_flash_sector_xlat.sv
module tb_flash_sector_xlat;

    localparam int SW   = 20;
    localparam int MASK = 1024;   // R7: ID 0x0048 -> 1 << (6 + 4)

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [3:0]    reg_sel = 4'd0;
    logic [15:0]   reg_wdata = 16'd0;
    logic [15:0]   reg_rdata;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic          xfer_valid;
    logic [SW-1:0] xfer_sector;
    logic [8:0]    xfer_count;
    logic          buf_is_data;
    logic          buf_bank;
    logic [1:0]    buf_offset;

    flash_sector_xlat dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .xfer_valid(xfer_valid), .xfer_sector(xfer_sector),
        .xfer_count(xfer_count), .buf_is_data(buf_is_data),
        .buf_bank(buf_bank), .buf_offset(buf_offset)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // Behavioural reference state
    int m_regs[8];
    int m_buf, m_cnt;
    int m_valid, m_sec, m_scnt, m_data, m_bank, m_off;

    function automatic int blockfield(int blk);
        return (blk & 'hFFF) | (((blk >> 15) & 1) != 0 ? MASK : 0);
    endfunction

    function automatic int exp_rdata(int sel);
        if (sel < 8) return m_regs[sel];
        if (sel == 8) return (m_buf << 8) | ((m_cnt - 1) & 2);
        return 0;
    endfunction

    task automatic model_reset();
        foreach (m_regs[i]) m_regs[i] = 0;
        m_buf = 0; m_cnt = 1;
        m_valid = 0; m_sec = 0; m_scnt = 0; m_data = 0; m_bank = 0; m_off = 0;
    endtask

    task automatic model_clock();
        int blk, pg;
        if (rst) begin
            model_reset();
            return;
        end
        m_valid = 0;
        if (cmd_valid && cmd_op != 2'd3) begin
            m_valid = 1;
            blk = (cmd_op == 2'd1) ? m_regs[2] : m_regs[0];
            pg  = (cmd_op == 2'd1) ? m_regs[3] : m_regs[7];
            if (cmd_op == 2'd2) begin
                m_sec = blockfield(blk) * 256;
                m_scnt = 256;
            end else begin
                m_sec = blockfield(blk) * 256 + (pg & 255);
                m_scnt = m_cnt;
            end
            m_data = (m_buf >> 3) & 1;
            m_bank = (m_buf >> 2) & 1;
            m_off  = m_buf & 3;
        end
        if (reg_wr) begin
            if (reg_sel < 8) m_regs[reg_sel] = reg_wdata;
            else if (reg_sel == 8) begin
                m_buf = (reg_wdata >> 8) & 15;
                m_cnt = (reg_wdata & 3) == 0 ? 4 : (reg_wdata & 3);
            end
        end
    endtask

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("xfer_valid", int'(xfer_valid), m_valid);
        chk("xfer_sector", int'(xfer_sector), m_sec);
        chk("xfer_count", int'(xfer_count), m_scnt);
        chk("buf_is_data", int'(buf_is_data), m_data);
        chk("buf_bank", int'(buf_bank), m_bank);
        chk("buf_offset", int'(buf_offset), m_off);
        chk("reg_rdata", int'(reg_rdata), exp_rdata(int'(reg_sel)));
    endtask

    // One clock: model follows the edge, outputs compared at the falling edge
    task automatic cyc();
        @(posedge clk);
        model_clock();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(int sel, int val);
        reg_wr = 1'b1; reg_sel = 4'(sel); reg_wdata = 16'(val);
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic rd(int sel);
        reg_sel = 4'(sel);
        #1;
        chk("readback", int'(reg_rdata), exp_rdata(sel));
        cyc();
    endtask

    task automatic cmd(int op);
        cmd_valid = 1'b1; cmd_op = 2'(op);
        cyc();
        cmd_valid = 1'b0;
        cyc();   // result cycle
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        cyc(); cyc();
        rst = 1'b0;
        cyc();

        cur_req = "R1";
        for (int i = 0; i < 9; i++) rd(i);
        cmd(0);
        chk("reset count", int'(xfer_count), 1);

        cur_req = "R2";
        for (int i = 0; i < 8; i++) wr(i, 'h1111 * (i + 1) ^ 'h8421);
        for (int i = 0; i < 8; i++) rd(i);

        cur_req = "R3";
        for (int f = 0; f < 4; f++) begin
            wr(8, 'hA500 | (f * 4) | f);
            rd(8);
            cmd(0);
        end

        cur_req = "R4";
        wr(0, 'h0123); wr(7, 'hFF9E); wr(8, 'h0002);
        cmd(0);
        chk("src sector", int'(xfer_sector), 'h123 * 256 + 'h9E);
        wr(7, 'h0001); cmd(0);

        cur_req = "R5";
        wr(2, 'h0456); wr(3, 'h0047); wr(8, 'h0003);
        cmd(1);
        chk("dst sector", int'(xfer_sector), 'h456 * 256 + 'h47);

        cur_req = "R6";
        wr(0, 'h7FFF); cmd(0);
        wr(0, 'h8400); cmd(0);
        chk("or no carry", int'(xfer_sector), 'h400 * 256 + (m_regs[7] & 255));
        wr(0, 'hF123); cmd(0);

        cur_req = "R7";
        wr(0, 'h8000); wr(7, 'h0000); cmd(0);
        chk("mask only", int'(xfer_sector), MASK * 256);

        cur_req = "R8";
        wr(0, 'h8155); wr(7, 'h00FF); cmd(2);
        chk("erase count", int'(xfer_count), 256);
        chk("erase sector", int'(xfer_sector), ('h155 | MASK) * 256);

        cur_req = "R9";
        for (int b = 0; b < 16; b++) begin
            wr(8, (b << 8) | 1);
            cmd(b % 3);
        end

        cur_req = "R10";
        cmd_valid = 1'b1; cmd_op = 2'd0; cyc();
        cmd_op = 2'd1; cyc();
        cmd_valid = 1'b0; cyc(); cyc(); cyc();
        // command together with a write: old register values apply
        cmd_valid = 1'b1; cmd_op = 2'd0;
        reg_wr = 1'b1; reg_sel = 4'd0; reg_wdata = 16'h0777;
        cyc();
        cmd_valid = 1'b0; reg_wr = 1'b0;
        cyc(); cmd(0);

        cur_req = "R11";
        wr(0, 'h0001);
        cmd(3);
        chk("rsvd no valid", int'(xfer_valid), 0);
        cyc();

        cur_req = "R12";
        for (int s = 9; s < 16; s++) wr(s, 'hFFFF);
        for (int s = 0; s < 16; s++) rd(s);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule